// File: doc/BRIEF.md
# Serial Test Instruction Transmitter

This block is the host-side driver for a four-line serial test port: two functional clocks (`crck_o`, `ptck_o`), a shift clock (`testck_o`) and a serial data line (`testin_o`). A controller gives it one command at a time over a valid/ready handshake. The block turns each command into a fixed series of pin patterns. Each pattern is held for `PHASE_CLKS` system clocks, so one parameter sets every setup, hold and pulse width on the port.

Seven opcodes are defined. Three of them shift words: a raw 22-bit instruction, a fixed 9-bit wait word, and a control-register write. A register write is shifted with its address and data inverted. Two write opcodes exist, and they differ in the clock tail that follows the shift. The remaining opcodes pulse the clocks a given number of times: `crck` alone, `ptck` alone, or the two as a group. The block switches no programming voltage and reads nothing back from the target. Command sequencing is left to the controller above it.

Top module: `sti_tx`

## Requirements
- R1: After reset, and in every cycle in which `cmd_ready_o` is high, the port is idle: crck=1, testck=1, testin=0, ptck=0.
- R2: A command is accepted in a cycle in which `cmd_valid_i` and `cmd_ready_o` are both high. In the following cycle `cmd_ready_o` goes low and the port is still idle. The command's N phases then follow one after another, each held exactly `PHASE_CLKS` cycles. `cmd_ready_o` therefore stays low for N*`PHASE_CLKS`+1 cycles, and inputs presented while it is low are ignored.
- R3: Opcode 0 shifts `cmd_word_i[21:0]` bit 0 first. Each bit takes two phases: first (crck=1, testck=0, testin=bit, ptck=0), then (crck=1, testck=1, testin=bit, ptck=0). No clock tail follows the last bit.
- R4: `testin_o` never changes in the cycle in which `testck_o` rises.
- R5: Opcode 1 shifts the 9-bit constant 9'b000100101, bit 0 first. It is followed by one crck cycle: (0,1,0,0) then (1,1,0,0), with the values given in the order crck, testck, testin, ptck.
- R6: Opcodes 2 and 3 shift a 22-bit word. Its bits [7:0] are the inverted address `cmd_word_i[7:0]`, its bits [15:8] are the inverted data `cmd_word_i[15:8]`, and its bits [21:16] are zero. `cmd_word_i[21:16]` is ignored for these opcodes.
- R7: Opcode 2 follows the shift with one crck cycle: (0,1,0,0), then (1,1,0,0).
- R8: Opcode 3 follows the shift with (0,1,0,0), then (0,1,0,1), then (1,1,0,0).
- R9: Opcode 4 gives `cmd_word_i[CNT_W-1:0]` crck cycles. Each cycle is (0,1,0,0) then (1,1,0,0).
- R10: Opcode 5 gives the counted number of ptck cycles. Each is (1,1,0,1) then (1,1,0,0), and ptck is high only while testck is high.
- R11: Opcode 6 gives the counted number of groups. Each group is (0,1,0,0), (0,1,0,1), (1,1,0,0).
- R12: Opcode 7, or a pulse opcode (4 to 6) with a count of zero, is accepted but has no effect. The port stays idle and `cmd_ready_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block can take a command |
| cmd_op_i | input | 3 | Opcode 0..7 |
| cmd_word_i | input | 22 | Raw instruction, {data, address} in [15:0], or count in [CNT_W-1:0] |
| crck_o | output | 1 | Core clock line |
| ptck_o | output | 1 | Peripheral clock line |
| testck_o | output | 1 | Shift clock line |
| testin_o | output | 1 | Serial data line |

## Verification
The raw shift is driven with all-zero, all-one, alternating and irregular words. The all-zero and all-one words catch a stuck data line. The alternating word exposes a shift by one bit, and the irregular word exposes bit reversal. Register writes use address and data values whose inverses are distinctive, while junk sits in the ignored upper bits, so a missing inversion or a leak of those bits shows up. The pulse commands are run with counts of 1, 2, 3 and 5 so that off-by-one repeat errors show, and with a count of 0 and the spare opcode. Commands are also issued back to back, each one held waiting while the block is busy.

// File: rtl/sti_pkg.sv
package sti_pkg;
  localparam int unsigned INST_W  = 22;
  localparam int unsigned SHORT_W = 9;
  localparam logic [SHORT_W-1:0] SHORT_PAT = 9'b000100101;

  typedef enum logic [2:0] {
    OP_SHIFT  = 3'd0,
    OP_SHORT  = 3'd1,
    OP_WR_CR  = 3'd2,
    OP_WR_CP  = 3'd3,
    OP_CYC_CR = 3'd4,
    OP_CYC_PT = 3'd5,
    OP_CYC_CP = 3'd6,
    OP_NOP    = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SH_LO, ST_SH_HI,
    ST_CR_LO, ST_CR_HI,
    ST_CP_LO, ST_CP_PT, ST_CP_HI,
    ST_PT_HI, ST_PT_LO
  } st_e;

  typedef enum logic [1:0] {TAIL_NONE, TAIL_CR, TAIL_CP} tail_e;

  typedef struct packed {
    logic crck;
    logic testck;
    logic testin;
    logic ptck;
  } pins_t;

  localparam pins_t PINS_IDLE = '{crck: 1'b1, testck: 1'b1, testin: 1'b0, ptck: 1'b0};
endpackage

// File: rtl/sti_phase_timer.sv
module sti_phase_timer #(
  parameter int unsigned PHASE_CLKS = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (tick_o)       cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sti_shifter.sv
module sti_shifter #(
  parameter int unsigned W = 22
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [W-1:0]               word_i,
  input  logic [$clog2(W+1)-1:0]     len_i,
  input  logic                       adv_i,
  output logic                       bit_o,
  output logic                       last_o
);
  localparam int unsigned LW = $clog2(W + 1);

  logic [W-1:0]  sr_q;
  logic [LW-1:0] rem_q;

  assign bit_o  = sr_q[0];
  assign last_o = (rem_q == LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      sr_q  <= word_i;
      rem_q <= len_i;
    end else if (adv_i) begin
      sr_q  <= {1'b0, sr_q[W-1:1]};
      rem_q <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/sti_seq.sv
module sti_seq
  import sti_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  st_e              first_i,
  input  tail_e            tail_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             tick_i,
  input  logic             last_bit_i,
  output st_e              state_o,
  output logic             adv_o
);
  st_e              st_q, st_nxt;
  tail_e            tail_q;
  logic [CNT_W-1:0] rep_q, rep_nxt;
  logic             more;

  assign state_o = st_q;
  assign more    = (rep_q > CNT_W'(1));

  always_comb begin
    st_nxt  = st_q;
    rep_nxt = rep_q;
    adv_o   = 1'b0;
    unique case (st_q)
      ST_SH_LO: st_nxt = ST_SH_HI;
      ST_SH_HI: begin
        adv_o = tick_i;
        if (!last_bit_i) st_nxt = ST_SH_LO;
        else begin
          unique case (tail_q)
            TAIL_CR: st_nxt = ST_CR_LO;
            TAIL_CP: st_nxt = ST_CP_LO;
            default: st_nxt = ST_IDLE;
          endcase
        end
      end
      ST_CR_LO: st_nxt = ST_CR_HI;
      ST_CR_HI: begin
        st_nxt  = more ? ST_CR_LO : ST_IDLE;
        rep_nxt = rep_q - 1'b1;
      end
      ST_PT_HI: st_nxt = ST_PT_LO;
      ST_PT_LO: begin
        st_nxt  = more ? ST_PT_HI : ST_IDLE;
        rep_nxt = rep_q - 1'b1;
      end
      ST_CP_LO: st_nxt = ST_CP_PT;
      ST_CP_PT: st_nxt = ST_CP_HI;
      ST_CP_HI: begin
        st_nxt  = more ? ST_CP_LO : ST_IDLE;
        rep_nxt = rep_q - 1'b1;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tail_q <= TAIL_NONE;
      rep_q  <= '0;
    end else if (start_i) begin
      st_q   <= first_i;
      tail_q <= tail_i;
      rep_q  <= count_i;
    end else if (tick_i) begin
      st_q   <= st_nxt;
      rep_q  <= rep_nxt;
    end
  end
endmodule

// File: rtl/sti_tx.sv
module sti_tx
  import sti_pkg::*;
#(
  parameter int unsigned PHASE_CLKS = 13,
  parameter int unsigned CNT_W      = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  output logic        cmd_ready_o,
  input  logic [2:0]  cmd_op_i,
  input  logic [21:0] cmd_word_i,
  output logic        crck_o,
  output logic        ptck_o,
  output logic        testck_o,
  output logic        testin_o
);
  localparam int unsigned LW = $clog2(INST_W + 1);

  logic              accept, tick, adv, sh_bit, sh_last, busy_q;
  st_e               st, first_d;
  tail_e             tail_d;
  logic [CNT_W-1:0]  count_d, word_cnt;
  logic [INST_W-1:0] word_d;
  logic [LW-1:0]     len_d;
  pins_t             pins_d, pins_q;

  assign accept   = cmd_valid_i && cmd_ready_o;
  assign word_cnt = cmd_word_i[CNT_W-1:0];

  // command decode
  always_comb begin
    word_d  = cmd_word_i;
    len_d   = LW'(INST_W);
    first_d = ST_SH_LO;
    tail_d  = TAIL_NONE;
    count_d = CNT_W'(1);
    unique case (op_e'(cmd_op_i))
      OP_SHIFT: ;
      OP_SHORT: begin
        word_d = INST_W'(SHORT_PAT);
        len_d  = LW'(SHORT_W);
        tail_d = TAIL_CR;
      end
      OP_WR_CR, OP_WR_CP: begin
        word_d = {6'b0, ~cmd_word_i[15:8], ~cmd_word_i[7:0]};
        tail_d = (cmd_op_i == OP_WR_CR) ? TAIL_CR : TAIL_CP;
      end
      OP_CYC_CR, OP_CYC_PT, OP_CYC_CP: begin
        count_d = word_cnt;
        if (word_cnt == '0)              first_d = ST_IDLE;
        else if (cmd_op_i == OP_CYC_CR)  first_d = ST_CR_LO;
        else if (cmd_op_i == OP_CYC_PT)  first_d = ST_PT_HI;
        else                             first_d = ST_CP_LO;
      end
      default: first_d = ST_IDLE;
    endcase
  end

  sti_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (st != ST_IDLE),
    .tick_o(tick)
  );

  sti_shifter #(.W(INST_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .word_i(word_d),
    .len_i (len_d),
    .adv_i (adv),
    .bit_o (sh_bit),
    .last_o(sh_last)
  );

  sti_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .first_i   (first_d),
    .tail_i    (tail_d),
    .count_i   (count_d),
    .tick_i    (tick),
    .last_bit_i(sh_last),
    .state_o   (st),
    .adv_o     (adv)
  );

  // phase to pin pattern
  always_comb begin
    pins_d = PINS_IDLE;
    unique case (st)
      ST_SH_LO: pins_d = '{crck: 1'b1, testck: 1'b0, testin: sh_bit, ptck: 1'b0};
      ST_SH_HI: pins_d = '{crck: 1'b1, testck: 1'b1, testin: sh_bit, ptck: 1'b0};
      ST_CR_LO, ST_CP_LO:
                pins_d = '{crck: 1'b0, testck: 1'b1, testin: 1'b0, ptck: 1'b0};
      ST_CP_PT: pins_d = '{crck: 1'b0, testck: 1'b1, testin: 1'b0, ptck: 1'b1};
      ST_PT_HI: pins_d = '{crck: 1'b1, testck: 1'b1, testin: 1'b0, ptck: 1'b1};
      default:  pins_d = PINS_IDLE;
    endcase
  end

  // registered pins: glitch-free clock lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q <= PINS_IDLE;
      busy_q <= 1'b0;
    end else begin
      pins_q <= pins_d;
      busy_q <= (st != ST_IDLE);
    end
  end

  assign cmd_ready_o = (st == ST_IDLE) && !busy_q;
  assign crck_o      = pins_q.crck;
  assign testck_o    = pins_q.testck;
  assign testin_o    = pins_q.testin;
  assign ptck_o      = pins_q.ptck;
endmodule

// File: rtl/sti_tx_chk.sv
module sti_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       cmd_ready_o,
  input logic [2:0] cmd_op_i,
  input logic       crck_o,
  input logic       ptck_o,
  input logic       testck_o,
  input logic       testin_o
);
  a_r1_idle_while_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (crck_o && testck_o && !testin_o && !ptck_o));

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && (cmd_op_i <= 3'd3)) |=> !cmd_ready_o);

  a_r4_testin_stable_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(testck_o) |-> $stable(testin_o));

  a_r3_crck_high_in_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !testck_o |-> (crck_o && !ptck_o));

  a_r10_ptck_under_testck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptck_o |-> testck_o);

  a_r12_nop_keeps_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && (cmd_op_i == 3'd7)) |=> cmd_ready_o);
endmodule

bind sti_tx sti_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o),
  .cmd_op_i   (cmd_op_i),
  .crck_o     (crck_o),
  .ptck_o     (ptck_o),
  .testck_o   (testck_o),
  .testin_o   (testin_o)
);

// File: tb/sti_tx_bench.sv
module sti_tx_bench;
  localparam int P = 3;
  localparam logic [3:0] IDLE_P = 4'b1100; // {crck,testck,testin,ptck}

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic [21:0] word = '0;
  logic        ready, crck, ptck, testck, testin;

  int checks = 0;
  int errors = 0;
  int tck_rises = 0;
  int crck_rises = 0;
  int ptck_rises = 0;

  typedef struct {logic [3:0] p; string tag;} ent_t;
  ent_t q[$];

  logic        acc_s = 1'b0;
  logic [2:0]  op_s = '0;
  logic [21:0] word_s = '0;
  logic [3:0]  prev_pins = IDLE_P;

  always #5 clk = ~clk;

  sti_tx #(.PHASE_CLKS(P), .CNT_W(8)) u_sti_tx (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_ready_o(ready),
    .cmd_op_i(op), .cmd_word_i(word),
    .crck_o(crck), .ptck_o(ptck), .testck_o(testck), .testin_o(testin)
  );

  function automatic void push_ph(logic [3:0] p, string tag);
    for (int i = 0; i < P; i++) q.push_back('{p: p, tag: tag});
  endfunction

  function automatic void push_bits(logic [21:0] w, int n, string tag);
    for (int i = 0; i < n; i++) begin
      push_ph({1'b1, 1'b0, w[i], 1'b0}, tag);
      push_ph({1'b1, 1'b1, w[i], 1'b0}, tag);
    end
  endfunction

  function automatic void model_cmd(logic [2:0] o, logic [21:0] w);
    int n;
    logic [21:0] wr;
    n  = int'(w[7:0]);
    wr = {6'b0, ~w[15:8], ~w[7:0]};
    if (o == 3'd7 || (o >= 3'd4 && n == 0)) return;
    q.push_back('{p: IDLE_P, tag: "R2"});
    case (o)
      3'd0: push_bits(w, 22, "R3");
      3'd1: begin
        push_bits(22'b000100101, 9, "R5");
        push_ph(4'b0100, "R5"); push_ph(4'b1100, "R5");
      end
      3'd2: begin
        push_bits(wr, 22, "R6");
        push_ph(4'b0100, "R7"); push_ph(4'b1100, "R7");
      end
      3'd3: begin
        push_bits(wr, 22, "R6");
        push_ph(4'b0100, "R8"); push_ph(4'b0101, "R8"); push_ph(4'b1100, "R8");
      end
      3'd4: for (int i = 0; i < n; i++) begin
        push_ph(4'b0100, "R9"); push_ph(4'b1100, "R9");
      end
      3'd5: for (int i = 0; i < n; i++) begin
        push_ph(4'b1101, "R10"); push_ph(4'b1100, "R10");
      end
      default: for (int i = 0; i < n; i++) begin
        push_ph(4'b0100, "R11"); push_ph(4'b0101, "R11"); push_ph(4'b1100, "R11");
      end
    endcase
  endfunction

  always @(posedge clk) if (rst_n) begin
    if (q.size() > 0) void'(q.pop_front());
    if (acc_s) model_cmd(op_s, word_s);
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    logic [3:0] act, exp_p;
    logic       exp_r;
    string      tag;
    act   = {crck, testck, testin, ptck};
    exp_p = (q.size() > 0) ? q[0].p : IDLE_P;
    exp_r = (q.size() == 0);
    tag   = (q.size() > 0) ? q[0].tag : "R1";
    checks++;
    if (act !== exp_p || ready !== exp_r) begin
      errors++;
      $display("FAIL %s t=%0t pins/ready actual=%b/%b expected=%b/%b",
               tag, $time, act, ready, exp_p, exp_r);
    end
    if (!prev_pins[2] && testck) begin
      tck_rises++;
      checks++;
      if (testin !== prev_pins[1]) begin
        errors++;
        $display("FAIL R4 testin at testck rise actual=%b expected=%b", testin, prev_pins[1]);
      end
    end
    if (!prev_pins[3] && crck) crck_rises++;
    if (!prev_pins[0] && ptck) ptck_rises++;
    prev_pins = act;
    acc_s  = valid & ready;
    op_s   = op;
    word_s = word;
  end

  task automatic send(logic [2:0] o, logic [21:0] w);
    @(posedge clk); #2;
    valid = 1'b1; op = o; word = w;
    do @(negedge clk); while (!ready);
    @(posedge clk); #2;
    valid = 1'b0;
    word  = 22'h2AAAAA; // junk while busy, must be ignored (R2)
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!ready || q.size() > 0);
  endtask

  task automatic expect_eq(int act, int exp, string tag, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int t0, c0, p0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    expect_eq(int'({ready, crck, testck, testin, ptck}), int'(5'b11100), "R1", "reset state");

    // R3 raw shift with several data patterns
    t0 = tck_rises;
    send(3'd0, 22'h000000); wait_idle();
    expect_eq(tck_rises - t0, 22, "R3", "testck rises");
    send(3'd0, 22'h3FFFFF); wait_idle();
    send(3'd0, 22'h155555); wait_idle();
    c0 = crck_rises;
    send(3'd0, 22'h0C3A71); wait_idle();
    expect_eq(crck_rises - c0, 0, "R3", "crck rises after raw shift");

    // R5 short wait
    t0 = tck_rises; c0 = crck_rises;
    send(3'd1, 22'h3FFFFF); wait_idle();
    expect_eq(tck_rises - t0, 9, "R5", "testck rises");
    expect_eq(crck_rises - c0, 1, "R5", "crck rises");

    // R6/R7/R8 register writes with junk in ignored bits
    c0 = crck_rises; p0 = ptck_rises;
    send(3'd2, 22'h3F0838); wait_idle();
    expect_eq(crck_rises - c0, 1, "R7", "crck rises");
    expect_eq(ptck_rises - p0, 0, "R7", "ptck rises");
    p0 = ptck_rises;
    send(3'd3, 22'h15003A); wait_idle();
    expect_eq(ptck_rises - p0, 1, "R8", "ptck rises");

    // R9/R10/R11 counted pulses, back to back
    c0 = crck_rises; p0 = ptck_rises;
    send(3'd4, 22'h000005);
    send(3'd5, 22'h000002);
    send(3'd6, 22'h000003);
    send(3'd4, 22'h000001); wait_idle();
    expect_eq(crck_rises - c0, 5 + 3 + 1, "R9", "crck rises");
    expect_eq(ptck_rises - p0, 2 + 3, "R10", "ptck rises");

    // R12 no-op forms
    c0 = crck_rises; p0 = ptck_rises; t0 = tck_rises;
    send(3'd7, 22'h3FFFFF);
    send(3'd4, 22'h3FFF00);
    send(3'd6, 22'h000000);
    repeat (4) @(negedge clk);
    expect_eq(crck_rises - c0 + ptck_rises - p0 + tck_rises - t0, 0, "R12", "edges after no-op");
    expect_eq(int'(ready), 1, "R12", "ready");

    // R11 after a no-op
    p0 = ptck_rises;
    send(3'd6, 22'h000001); wait_idle();
    expect_eq(ptck_rises - p0, 1, "R11", "ptck rises");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule